// File: doc/BRIEF.md
# Deferred Constant-Time PIN Checker

The block takes a PIN from a keypad-style source, one 4-bit digit per valid strobe, and holds the digits in a shift register. No digit is compared while entry is in progress, so the logic switches the same way and takes the same time whether a digit is right or wrong. Once the last of the N digits has been taken, one cycle evaluates all digits against the stored reference together. That evaluation XORs every digit with the reference and ORs the result down to a single mismatch bit. One cycle later the block gives a one-cycle match or fail pulse.

The reference PIN is loaded one digit at a time through a write port. Index 0 holds the first digit entered. A clear input drops a partly entered PIN. A saturating failed-attempt counter raises a lockout flag that stays set until reset. While the flag is set, all keypad input is ignored. After every comparison the entered digits are wiped.

Top module: `pin_checker`

## Requirements
- R1: A digit is taken on each cycle with `digit_valid_i` high, unless `clear_i` is high or lockout is set. Digits are matched to reference positions in entry order, so the first digit entered is checked against reference index 0.
- R2: The Nth digit is sampled at clock edge k. The result pulse is high in the cycle between edges k+1 and k+2. It is low in the cycle before that and in the cycle after that. This latency does not depend on the digit values or on the idle gaps between digits.
- R3: `match_o` pulses only when all N entered digits equal the reference. Otherwise `fail_o` pulses, including when only the first digit or only the last digit differs. The two outputs are never high together.
- R4: No result pulse appears before the Nth digit has been taken, even when every digit entered so far is correct.
- R5: `clear_i` empties the entry register and produces no result. This also holds when `clear_i` is high in the comparison cycle itself. The next result depends only on digits entered after the clear.
- R6: Each fail pulse raises the failed-attempt count (3 bits), which saturates at LOCK_LIMIT (default 3). A match pulse sets the count back to zero. `lockout_o` goes high in the cycle after the fail pulse that brings the count to LOCK_LIMIT.
- R7: While `lockout_o` is high, digits are ignored and no result pulse is produced. Only reset clears `lockout_o`.
- R8: A write with `ref_we_i` high stores `ref_digit_i` at reference index `ref_idx_i`, where 0 is the first digit entered. Later comparisons use the new value.
- R9: After every comparison the entry register is cleared. A digit strobed in the comparison cycle is not taken. The next result therefore needs N fresh digits.
- R10: After reset, all outputs are low, the failed-attempt count is zero, and every reference digit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| digit_i | input | 4 | Entered digit value |
| digit_valid_i | input | 1 | One-cycle strobe qualifying `digit_i` |
| clear_i | input | 1 | Discard the partial entry, no result |
| ref_we_i | input | 1 | Reference digit write enable |
| ref_idx_i | input | $clog2(N) | Reference digit index, 0 = first entered |
| ref_digit_i | input | 4 | Reference digit value to write |
| match_o | output | 1 | One-cycle pulse: full PIN matched |
| fail_o | output | 1 | One-cycle pulse: full PIN mismatched |
| lockout_o | output | 1 | Failed-attempt limit reached, sticky until reset |

## Verification
The assertions check on every cycle that:
- a result pulse always follows the full-entry cycle and never comes without one;
- match and fail are never high together;
- the entry register is empty while a result is shown;
- clear removes any pending result;
- lockout is sticky, begins only after a fail pulse, and blocks all results.

Only the bench scenarios can show which digit position is checked against which reference index, and that the match/fail decision is correct for nearly correct PINs and for randomly drawn ones. The same holds for the exact latency across random idle gaps, the effect of reference writes, and the saturating count of fails against matches up to lockout.

// File: rtl/pin_chk_pkg.sv
package pin_chk_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/pin_ref_store.sv
module pin_ref_store
  import pin_chk_pkg::*;
#(
  parameter int unsigned N     = 6,
  localparam int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned DATA_W = N * DIGIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  digit_t            digit_i,
  output logic [DATA_W-1:0] ref_o
);
  // index 0 is the first entered digit, which ends up in the top nibble
  for (genvar k = 0; k < N; k++) begin : g_slot
    digit_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (we_i && (idx_i == IDX_W'(k))) begin
        slot_q <= digit_i;
      end
    end
    assign ref_o[DIGIT_W*(N-1-k) +: DIGIT_W] = slot_q;
  end
endmodule

// File: rtl/pin_accum.sv
module pin_accum
  import pin_chk_pkg::*;
#(
  parameter int unsigned N      = 6,
  localparam int unsigned CNT_W  = $clog2(N + 1),
  localparam int unsigned DATA_W = N * DIGIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  digit_t            digit_i,
  input  logic              clear_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o
);
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  count_q;
  logic              full_q;

  // no comparison here: digits only shift in, whatever their value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      count_q <= '0;
      full_q  <= 1'b0;
    end else if (clear_i || full_q) begin
      // full_q marks the compare cycle; wipe the entry afterwards
      data_q  <= '0;
      count_q <= '0;
      full_q  <= 1'b0;
    end else if (take_i) begin
      data_q  <= {data_q[DATA_W-DIGIT_W-1:0], digit_i};
      count_q <= count_q + CNT_W'(1);
      full_q  <= (count_q == CNT_W'(N - 1));
    end
  end

  assign data_o  = data_q;
  assign count_o = count_q;
  assign full_o  = full_q;
endmodule

// File: rtl/pin_compare.sv
module pin_compare
  import pin_chk_pkg::*;
#(
  parameter int unsigned N      = 6,
  localparam int unsigned DATA_W = N * DIGIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [DATA_W-1:0] entered_i,
  input  logic [DATA_W-1:0] ref_i,
  output logic              match_o,
  output logic              fail_o
);
  logic [N-1:0] digit_ne;
  logic         mismatch;
  logic         match_q, fail_q;

  for (genvar k = 0; k < N; k++) begin : g_dig
    assign digit_ne[k] = |(entered_i[DIGIT_W*k +: DIGIT_W] ^ ref_i[DIGIT_W*k +: DIGIT_W]);
  end
  assign mismatch = |digit_ne;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      match_q <= go_i && !mismatch;
      fail_q  <= go_i && mismatch;
    end
  end

  assign match_o = match_q;
  assign fail_o  = fail_q;
endmodule

// File: rtl/pin_attempts.sv
module pin_attempts #(
  parameter int unsigned LOCK_LIMIT = 3,
  parameter int unsigned CNT_W      = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic fail_i,
  output logic lock_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             locked;

  assign locked = (cnt_q >= CNT_W'(LOCK_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!locked) begin
      if (fail_i)       cnt_q <= cnt_q + CNT_W'(1);
      else if (match_i) cnt_q <= '0;
    end
  end

  assign lock_o = locked;
endmodule

// File: rtl/pin_checker.sv
module pin_checker
  import pin_chk_pkg::*;
#(
  parameter int unsigned N          = 6,
  parameter int unsigned LOCK_LIMIT = 3,
  localparam int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned CNT_W  = $clog2(N + 1),
  localparam int unsigned DATA_W = N * DIGIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       digit_i,
  input  logic             digit_valid_i,
  input  logic             clear_i,
  input  logic             ref_we_i,
  input  logic [IDX_W-1:0] ref_idx_i,
  input  logic [3:0]       ref_digit_i,
  output logic             match_o,
  output logic             fail_o,
  output logic             lockout_o
);
  logic [DATA_W-1:0] acc_data;
  logic [DATA_W-1:0] ref_data;
  logic [CNT_W-1:0]  acc_count;
  logic              acc_full;
  logic              take;
  logic              go;

  assign take = digit_valid_i && !clear_i && !lockout_o && !acc_full;
  assign go   = acc_full && !clear_i;

  pin_ref_store #(.N(N)) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ref_we_i),
    .idx_i   (ref_idx_i),
    .digit_i (ref_digit_i),
    .ref_o   (ref_data)
  );

  pin_accum #(.N(N)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .digit_i (digit_i),
    .clear_i (clear_i),
    .data_o  (acc_data),
    .count_o (acc_count),
    .full_o  (acc_full)
  );

  pin_compare #(.N(N)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .entered_i (acc_data),
    .ref_i     (ref_data),
    .match_o   (match_o),
    .fail_o    (fail_o)
  );

  pin_attempts #(.LOCK_LIMIT(LOCK_LIMIT), .CNT_W(3)) u_att (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match_o),
    .fail_i  (fail_o),
    .lock_o  (lockout_o)
  );
endmodule

// File: rtl/pin_checker_sva.sv
module pin_checker_sva #(
  parameter int unsigned N = 6,
  localparam int unsigned CNT_W  = $clog2(N + 1),
  localparam int unsigned DATA_W = N * 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              match_o,
  input logic              fail_o,
  input logic              lockout_o,
  input logic              full_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [DATA_W-1:0] data_i
);
  a_r2_result_follows_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i && !clear_i) |=> (match_o || fail_o));

  a_r4_no_early_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o || fail_o) |-> $past(full_i));

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(match_o && fail_o));

  a_r9_flushed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o || fail_o) |-> (count_i == '0 && data_i == '0 && !full_i));

  a_r5_clear_no_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_i == '0 && !match_o && !fail_o));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |=> lockout_o);

  a_r7_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |-> (!match_o && !fail_o && count_i == '0));

  a_r6_lock_after_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lockout_o) |-> $past(fail_o));
endmodule

bind pin_checker pin_checker_sva #(.N(N)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .match_o   (match_o),
  .fail_o    (fail_o),
  .lockout_o (lockout_o),
  .full_i    (acc_full),
  .count_i   (acc_count),
  .data_i    (acc_data)
);

// File: tb/pin_checker_tb.sv
`timescale 1ns/1ps
module pin_checker_tb;
  localparam int N = 6;
  localparam int LIMIT = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] digit_i = '0;
  logic       digit_valid_i = 1'b0;
  logic       clear_i = 1'b0;
  logic       ref_we_i = 1'b0;
  logic [2:0] ref_idx_i = '0;
  logic [3:0] ref_digit_i = '0;
  logic       match_o, fail_o, lockout_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] ref_m [N];
  int fails_m;
  typedef logic [3:0] pin_t [N];

  always #2 clk_i = ~clk_i;

  pin_checker #(.N(N), .LOCK_LIMIT(LIMIT)) u_dut (
    .clk_i, .rst_ni, .digit_i, .digit_valid_i, .clear_i,
    .ref_we_i, .ref_idx_i, .ref_digit_i, .match_o, .fail_o, .lockout_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit pin_eq(input pin_t p);
    for (int k = 0; k < N; k++) if (p[k] != ref_m[k]) return 0;
    return 1;
  endfunction

  function automatic bit locked_m();
    return fails_m >= LIMIT;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < N; k++) ref_m[k] = '0;
    fails_m = 0;
  endtask

  task automatic wr_ref(input int k, input logic [3:0] d);
    @(negedge clk_i);
    ref_we_i = 1'b1; ref_idx_i = 3'(k); ref_digit_i = d;
    @(negedge clk_i);
    ref_we_i = 1'b0;
    ref_m[k] = d;
  endtask

  task automatic send(input logic [3:0] d, input int gap);
    repeat (gap) @(negedge clk_i);
    @(negedge clk_i);
    digit_i = d; digit_valid_i = 1'b1;
    @(negedge clk_i);
    digit_valid_i = 1'b0;
  endtask

  task automatic quiet(input string req);
    chk(!match_o && !fail_o, req, {match_o, fail_o}, 0);
  endtask

  // full attempt; checks the exact pulse cycle and models the attempt counter
  task automatic attempt(input pin_t p, input bit rand_gap, input string req);
    bit exp_m, was_locked;
    was_locked = locked_m();
    exp_m = pin_eq(p);
    for (int k = 0; k < N; k++) begin
      send(p[k], rand_gap ? int'($urandom_range(0, 3)) : 0);
      if (k < N - 1) quiet({req, " R4 partial"});
    end
    quiet({req, " R2 early"});
    @(negedge clk_i);
    if (was_locked) begin
      quiet({req, " R7 locked"});
    end else begin
      chk(match_o == exp_m && fail_o == !exp_m, {req, " R3 result"},
          {match_o, fail_o}, {exp_m, !exp_m});
      if (exp_m) fails_m = 0;
      else if (fails_m < LIMIT) fails_m++;
    end
    @(negedge clk_i);
    quiet({req, " R2 one-cycle"});
    chk(lockout_o == locked_m(), {req, " R6 lockout"}, lockout_o, locked_m());
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pin_t p;
    int seed;
    seed = int'($urandom(32'h5eed_1234));
    do_reset();
    // R10 reset state
    chk(!match_o && !fail_o && !lockout_o, "R10 reset outputs", {match_o, fail_o, lockout_o}, 0);
    p = '{default: 4'h0};
    attempt(p, 0, "R10 zero ref");

    // R8 reference write, R1 order
    for (int k = 0; k < N; k++) wr_ref(k, 4'(k + 1));
    p = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6};
    attempt(p, 0, "R8 R1 correct");
    p = '{4'h6, 4'h5, 4'h4, 4'h3, 4'h2, 4'h1};
    attempt(p, 0, "R1 reversed");
    p = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h0};
    attempt(p, 1, "R3 last differs");
    // R6 match resets count after two fails
    p = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6};
    attempt(p, 1, "R6 reset count");
    p = '{4'h0, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6};
    attempt(p, 0, "R3 first differs");
    p = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6};
    attempt(p, 0, "R6 clear again");

    // R5 clear during entry
    send(4'h9, 0); send(4'h9, 0); send(4'h9, 0);
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
    quiet("R5 clear no result");
    attempt(p, 0, "R5 after clear");

    // R5 clear in compare cycle
    for (int k = 0; k < N; k++) send(p[k], 0);
    clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
    quiet("R5 clear at compare");
    @(negedge clk_i);
    quiet("R5 clear at compare late");

    // R9 digit in compare cycle ignored, register wiped
    for (int k = 0; k < N; k++) send(p[k], 0);
    digit_i = 4'h1; digit_valid_i = 1'b1;
    @(negedge clk_i); digit_valid_i = 1'b0;
    chk(match_o && !fail_o, "R9 result", {match_o, fail_o}, 2);
    for (int k = 0; k < N - 1; k++) send(p[k], 0);
    repeat (3) begin @(negedge clk_i); quiet("R9 five digits only"); end
    send(p[N-1], 0);
    @(negedge clk_i);
    chk(match_o && !fail_o, "R9 sixth digit completes", {match_o, fail_o}, 2);

    // R6/R7 lockout
    p = '{4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
    repeat (LIMIT) attempt(p, 1, "R6 fail to lock");
    chk(lockout_o == 1'b1, "R7 locked", lockout_o, 1);
    p = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6};
    attempt(p, 0, "R7 ignored");
    chk(lockout_o == 1'b1, "R7 sticky", lockout_o, 1);
    do_reset();
    chk(lockout_o == 1'b0, "R10 reset clears lock", lockout_o, 0);
    attempt(p, 0, "R10 ref zero after reset");

    // random attempts
    for (int t = 0; t < 60; t++) begin
      if (t % 10 == 0)
        for (int k = 0; k < N; k++) wr_ref(k, 4'($urandom_range(0, 15)));
      for (int k = 0; k < N; k++) p[k] = ref_m[k];
      case ($urandom_range(0, 2))
        0: ;
        1: begin int j; j = int'($urandom_range(0, N - 1)); p[j] = p[j] ^ 4'($urandom_range(1, 15)); end
        default: for (int k = 0; k < N; k++) p[k] = 4'($urandom_range(0, 15));
      endcase
      attempt(p, 1, "R3 random");
      if (locked_m()) begin
        logic [3:0] keep [N];
        for (int k = 0; k < N; k++) keep[k] = ref_m[k];
        do_reset();
        for (int k = 0; k < N; k++) wr_ref(k, keep[k]);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule